// File: doc/BRIEF.md
# Descriptor Chaining Sequencer

This block walks the chain of two-word command descriptors that make up a channel program for one I/O subchannel. It fetches each descriptor from memory through a simple read port. It follows jump descriptors to their target address. For every data descriptor it hands address, byte count, skip flag and protection key to the byte datapath through a one-cycle load strobe. It then waits for the datapath to report that the count has run out.

When the count runs out, the descriptor's flags decide what happens next. A set data-chain flag fetches the next descriptor and continues the same device order. The device sees no break, even when the new descriptor carries a different skip flag or key. A set command-chain flag closes the current order and opens a new one from the next descriptor. With neither flag set, the program ends normally. An interrupt request is raised at each count exhaustion whose descriptor asks for one. Runaway jump chains and malformed descriptors end the program with an error pulse.

The controller has six states. IDLE waits for `start`. FETCH0 reads the first word. FETCH1 reads the second word. DECODE classifies the descriptor. RUN waits for `count_zero`. DONE lasts one cycle and ends the program. The transitions are:
- start: IDLE to FETCH0.
- word0 accepted: FETCH0 to FETCH1.
- word1 accepted: FETCH1 to DECODE.
- jump: DECODE to FETCH0.
- data descriptor: DECODE to RUN.
- fault: DECODE to DONE.
- chain: RUN to FETCH0 on `count_zero` with either chain flag set.
- last: RUN to DONE on `count_zero` with neither flag set.
- retire: DONE to IDLE.

Top module: `desc_chain_seq`

## Requirements
- R1: After `start`, each descriptor is read as two words: the first at the descriptor's byte address and the second at that address plus 4. `mem_addr` is held steady while `mem_req` waits for `mem_valid`.
- R2: Word layout. Word0 has the order code in [31:24] and the memory address in [23:0]. Word1 has the data-chain flag in [31], the command-chain flag in [30], the interrupt flag in [29], skip in [28], reserved bits in [27:24], an 8-bit key in [23:16] and a 16-bit byte count in [15:0]. For a data descriptor, `load_en` pulses for one cycle with `load_addr`, `load_count`, `load_skip` and `load_key` taken from those fields. When that descriptor starts an order, `order_new` pulses with `order_code` = word0[31:24].
- R3: When `count_zero` arrives with the data-chain flag set, the next descriptor is fetched at the current descriptor address plus 8. Across that fetch, `dev_active` stays 1, no `order_new` or `order_end` is given, and the new skip and key are only loaded.
- R4: A descriptor with order code 8'h08 is a jump. No load is made, and the next fetch starts at its word0[23:0].
- R5: A third jump in a row, with no data descriptor in between, ends the program. It gives one `prog_err` pulse, no `order_end`, and leaves `dev_active` low.
- R6: `irq_req` pulses once at each `count_zero` consumed in RUN whose descriptor has the interrupt flag set. This holds whether or not chaining follows.
- R7: At `count_zero` with both chain flags clear, `order_end` pulses, `dev_active` falls, and `busy` returns low after the DONE cycle.
- R8: At `count_zero` with only the command-chain flag set, `order_end` pulses and `dev_active` falls. The next descriptor then gives a fresh `order_new`, even when its order code is unchanged.
- R9: `count_zero` outside RUN has no effect. It gives no interrupt, no order end, and no change to the fetch sequence.
- R10: Out of reset, `busy`, `mem_req`, `load_en`, `dev_active`, `irq_req`, `order_end` and `prog_err` are all 0.
- R11: When both chain flags are set, data chaining wins. The order continues with no `order_end` and no `order_new`.
- R12: A data descriptor with any reserved bit (word1[27:24]) nonzero is not loaded. The program ends with one `prog_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a channel program (sampled in IDLE) |
| start_addr | input | ADDR_W | Byte address of the first descriptor |
| count_zero | input | 1 | Datapath byte count has reached zero |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Read data |
| load_en | output | 1 | Load strobe for the datapath registers |
| load_addr | output | ADDR_W | Memory address to load |
| load_count | output | 16 | Byte count to load |
| load_skip | output | 1 | Skip flag to load |
| load_key | output | 8 | Protection key to load |
| order_new | output | 1 | A new device order starts |
| order_code | output | 8 | Order code for the new order |
| order_end | output | 1 | Current order completed normally |
| irq_req | output | 1 | Zero-count interrupt request |
| prog_err | output | 1 | Channel program error ended the program |
| dev_active | output | 1 | Device order in progress |
| busy | output | 1 | Program in progress |

## Verification
Assertions check these properties on every cycle: the read address is held while a request waits, the two words of a descriptor sit 4 bytes apart, the fetch after a jump goes to its target, data chaining keeps the device active, a new order never opens while one is active, error endings are silent to the device, and the idle outputs are quiet. The jump-run counter is also checked to stay within its bound. Only the bench scenarios can show the fields delivered on each load and the order codes of the orders. They also show the number of interrupts and the ordering of chained fetch addresses against a model. The remaining bench-only behaviours are flag precedence, early `count_zero` being ignored, and error endings mid-chain.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int WORD_W      = 32;
    localparam int CODE_W      = 8;
    localparam int TGT_W       = 24;
    localparam int KEY_W       = 8;
    localparam int CNT_W       = 16;
    localparam int RSV_W       = 4;
    localparam int BIT_DCHAIN  = 31;
    localparam int BIT_CCHAIN  = 30;
    localparam int BIT_IZC     = 29;
    localparam int BIT_SKIP    = 28;
    localparam int RSV_LSB     = 24;
    localparam int KEY_LSB     = 16;
    localparam int CODE_LSB    = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_DECODE,
        ST_RUN,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [TGT_W-1:0]  target;
        logic              dchain;
        logic              cchain;
        logic              izc;
        logic              skip;
        logic              rsvd_nz;
        logic [KEY_W-1:0]  key;
        logic [CNT_W-1:0]  count;
        logic              is_tic;
    } desc_t;
endpackage

// File: rtl/chain_field_decode.sv
module chain_field_decode
    import chain_pkg::*;
#(
    parameter logic [CODE_W-1:0] TIC_CODE = 8'h08
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output desc_t             fields
);
    always_comb begin
        fields.code    = word0[CODE_LSB +: CODE_W];
        fields.target  = word0[TGT_W-1:0];
        fields.dchain  = word1[BIT_DCHAIN];
        fields.cchain  = word1[BIT_CCHAIN];
        fields.izc     = word1[BIT_IZC];
        fields.skip    = word1[BIT_SKIP];
        fields.rsvd_nz = |word1[RSV_LSB +: RSV_W];
        fields.key     = word1[KEY_LSB +: KEY_W];
        fields.count   = word1[CNT_W-1:0];
        fields.is_tic  = (word0[CODE_LSB +: CODE_W] == TIC_CODE);
    end
endmodule

// File: rtl/chain_tic_guard.sv
module chain_tic_guard #(
    parameter int MAX_TIC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic full
);
    localparam int CW = $clog2(MAX_TIC + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TIC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clear) begin
            run_q <= '0;
        end else if (bump && run_q != LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign full = (run_q == LIMIT);

    // R5: consecutive jump count never passes its limit
    assert_tic_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT);
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
    import chain_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                MAX_TIC  = 2,
    parameter logic [CODE_W-1:0] TIC_CODE = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              count_zero,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              load_en,
    output logic [ADDR_W-1:0] load_addr,
    output logic [CNT_W-1:0]  load_count,
    output logic              load_skip,
    output logic [KEY_W-1:0]  load_key,
    output logic              order_new,
    output logic [CODE_W-1:0] order_code,
    output logic              order_end,
    output logic              irq_req,
    output logic              prog_err,
    output logic              dev_active,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_DESC = ADDR_W'(8);

    seq_state_t        state, nxt;
    logic [WORD_W-1:0] w0_q, w1_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              cont_q;
    logic              act_q;
    logic              err_q;
    desc_t             f;
    logic              tic_full;
    logic              tic_bump;
    logic              tic_clear;
    logic              dec_fault;

    chain_field_decode #(.TIC_CODE(TIC_CODE)) u_decode (
        .word0  (w0_q),
        .word1  (w1_q),
        .fields (f)
    );

    chain_tic_guard #(.MAX_TIC(MAX_TIC)) u_tic_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tic_clear),
        .bump  (tic_bump),
        .full  (tic_full)
    );

    always_comb begin
        dec_fault = f.is_tic ? tic_full : f.rsvd_nz;
        tic_bump  = (state == ST_DECODE) && f.is_tic && !tic_full;
        tic_clear = ((state == ST_DECODE) && !f.is_tic) ||
                    ((state == ST_IDLE) && start);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH0;
            ST_FETCH0: if (mem_valid) nxt = ST_FETCH1;
            ST_FETCH1: if (mem_valid) nxt = ST_DECODE;
            ST_DECODE: begin
                if (dec_fault)     nxt = ST_DONE;
                else if (f.is_tic) nxt = ST_FETCH0;
                else               nxt = ST_RUN;
            end
            ST_RUN: begin
                if (count_zero) nxt = (f.dchain || f.cchain) ? ST_FETCH0 : ST_DONE;
            end
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Descriptor context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q   <= '0;
            w1_q   <= '0;
            ptr_q  <= '0;
            cont_q <= 1'b0;
            act_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q  <= start_addr;
                        cont_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_FETCH0: if (mem_valid) w0_q <= mem_rdata;
                ST_FETCH1: begin
                    if (mem_valid) begin
                        w1_q  <= mem_rdata;
                        ptr_q <= ptr_q + STEP_DESC;
                    end
                end
                ST_DECODE: begin
                    if (dec_fault) begin
                        err_q <= 1'b1;
                        act_q <= 1'b0;
                    end else if (f.is_tic) begin
                        ptr_q <= f.target[ADDR_W-1:0];
                    end else begin
                        act_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (count_zero) begin
                        if (f.dchain) begin
                            cont_q <= 1'b1;
                        end else begin
                            cont_q <= 1'b0;
                            act_q  <= 1'b0;
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = (state == ST_FETCH0) || (state == ST_FETCH1);
        mem_addr   = (state == ST_FETCH1) ? ptr_q + STEP_WORD : ptr_q;
        load_en    = (state == ST_DECODE) && !f.is_tic && !dec_fault;
        load_addr  = f.target[ADDR_W-1:0];
        load_count = f.count;
        load_skip  = f.skip;
        load_key   = f.key;
        order_new  = load_en && !cont_q;
        order_code = f.code;
        irq_req    = (state == ST_RUN) && count_zero && f.izc;
        order_end  = (state == ST_RUN) && count_zero && !f.dchain;
        prog_err   = (state == ST_DONE) && err_q;
        dev_active = act_q;
    end

    // R1: address held while a read waits
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> $stable(mem_addr));

    // R1: second word follows the first by one word
    assert_word_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH0 && mem_valid) |=> (mem_addr == $past(mem_addr) + STEP_WORD));

    // R3: data chaining keeps the device order alive
    assert_chain_keeps_device_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && count_zero && f.dchain) |=> (dev_active && mem_req));

    // R4: a followed jump redirects the next fetch
    assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && f.is_tic && !dec_fault) |=>
            (mem_addr == $past(f.target[ADDR_W-1:0])));

    // R5: error endings are silent to the device
    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> (!dev_active && !order_end && !load_en));

    // R7: a normal end releases the device
    assert_end_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        order_end |=> !dev_active);

    // R8: a new order never opens over an active one
    assert_new_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        order_new |-> !dev_active);

    // R10: an idle sequencer drives nothing
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !load_en && !dev_active && !irq_req && !order_end));
endmodule

// File: tb/desc_chain_seq_bench.sv
`timescale 1ns/1ps
module desc_chain_seq_bench;
    localparam int AW = 24;
    localparam logic [7:0] TIC = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic        count_zero = 1'b0;
    logic        mem_req;
    logic [AW-1:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic        load_en;
    logic [AW-1:0] load_addr;
    logic [15:0] load_count;
    logic        load_skip;
    logic [7:0]  load_key;
    logic        order_new;
    logic [7:0]  order_code;
    logic        order_end;
    logic        irq_req;
    logic        prog_err;
    logic        dev_active;
    logic        busy;

    desc_chain_seq #(.ADDR_W(AW), .MAX_TIC(2), .TIC_CODE(TIC)) u_desc_chain_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .count_zero(count_zero), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .load_en(load_en),
        .load_addr(load_addr), .load_count(load_count), .load_skip(load_skip),
        .load_key(load_key), .order_new(order_new), .order_code(order_code),
        .order_end(order_end), .irq_req(irq_req), .prog_err(prog_err),
        .dev_active(dev_active), .busy(busy)
    );

    always #4 clk = ~clk;

    logic [31:0] mem [0:255];
    int checks = 0;
    int errors = 0;

    int ob_nld, ob_nnew, ob_end, ob_irq, ob_err, ob_fall, ob_nfa;
    logic [23:0] ob_addr [0:63];
    logic [15:0] ob_cnt  [0:63];
    logic        ob_skip [0:63];
    logic [7:0]  ob_key  [0:63];
    logic [7:0]  ob_code [0:63];
    logic [23:0] ob_fa   [0:127];

    int ex_nld, ex_nnew, ex_end, ex_irq, ex_err, ex_fall, ex_nfa;
    logic [23:0] ex_addr [0:63];
    logic [15:0] ex_cnt  [0:63];
    logic        ex_skip [0:63];
    logic [7:0]  ex_key  [0:63];
    logic [7:0]  ex_code [0:63];
    logic [23:0] ex_fa   [0:127];

    function automatic logic [31:0] mk0(input logic [7:0] code, input logic [23:0] a);
        return {code, a};
    endfunction

    function automatic logic [31:0] mk1(input bit dc, input bit cc, input bit izc, input bit skp,
                                        input logic [3:0] rsv, input logic [7:0] key,
                                        input logic [15:0] cnt);
        return {dc, cc, izc, skp, rsv, key, cnt};
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic put(input int ba, input logic [31:0] a, input logic [31:0] b);
        mem[ba/4]     = a;
        mem[ba/4 + 1] = b;
    endtask

    // Memory responder with random latency
    initial begin
        int lat;
        lat = 0;
        mem_valid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_valid = 1'b1;
                    mem_rdata = mem[mem_addr[9:2]];
                    if (ob_nfa < 128) ob_fa[ob_nfa] = mem_addr;
                    ob_nfa++;
                    lat = $urandom % 3;
                end else begin
                    lat--;
                end
            end
        end
    end

    // Output monitor, sampled between edges
    initial begin
        logic prev_act;
        prev_act = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (load_en) begin
                if (ob_nld < 64) begin
                    ob_addr[ob_nld] = load_addr;
                    ob_cnt[ob_nld]  = load_count;
                    ob_skip[ob_nld] = load_skip;
                    ob_key[ob_nld]  = load_key;
                end
                ob_nld++;
            end
            if (order_new) begin
                if (ob_nnew < 64) ob_code[ob_nnew] = order_code;
                ob_nnew++;
            end
            if (order_end) ob_end++;
            if (irq_req)   ob_irq++;
            if (prog_err)  ob_err++;
            if (prev_act && !dev_active) ob_fall++;
            prev_act = dev_active;
        end
    end

    // Reference walk of the channel program
    task automatic walk(input logic [23:0] sa);
        logic [23:0] p, q;
        logic [31:0] a, b;
        int tic;
        bit cont;
        ex_nld = 0; ex_nnew = 0; ex_end = 0; ex_irq = 0; ex_err = 0; ex_fall = 0; ex_nfa = 0;
        p = sa; tic = 0; cont = 0;
        for (int it = 0; it < 40; it++) begin
            q = p + 24'd4;
            a = mem[p[9:2]];
            b = mem[q[9:2]];
            if (ex_nfa < 127) begin
                ex_fa[ex_nfa] = p;
                ex_fa[ex_nfa+1] = q;
            end
            ex_nfa += 2;
            if (a[31:24] == TIC) begin
                tic++;
                if (tic > 2) begin
                    ex_err = 1;
                    if (cont) ex_fall++;
                    break;
                end
                p = a[23:0];
                continue;
            end
            tic = 0;
            if (b[27:24] != 4'h0) begin
                ex_err = 1;
                if (cont) ex_fall++;
                break;
            end
            if (ex_nld < 64) begin
                ex_addr[ex_nld] = a[23:0];
                ex_cnt[ex_nld]  = b[15:0];
                ex_skip[ex_nld] = b[28];
                ex_key[ex_nld]  = b[23:16];
            end
            ex_nld++;
            if (!cont) begin
                if (ex_nnew < 64) ex_code[ex_nnew] = a[31:24];
                ex_nnew++;
            end
            if (b[29]) ex_irq++;
            if (b[31]) begin
                cont = 1;
                p = p + 24'd8;
            end else begin
                ex_end++;
                ex_fall++;
                cont = 0;
                if (b[30]) p = p + 24'd8;
                else break;
            end
        end
    endtask

    task automatic run_prog(input logic [23:0] sa, input bit early_cz);
        int guard;
        ob_nld = 0; ob_nnew = 0; ob_end = 0; ob_irq = 0; ob_err = 0; ob_fall = 0; ob_nfa = 0;
        walk(sa);
        @(negedge clk);
        start = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        if (early_cz) begin
            count_zero = 1'b1;
            @(negedge clk);
            count_zero = 1'b0;
        end
        guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (load_en) begin
                repeat (1 + $urandom % 4) @(negedge clk);
                count_zero = 1'b1;
                @(negedge clk);
                count_zero = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        chk("R7", "program terminates", guard < 3000, 1);
        chk("R7", "busy after end", busy, 0);
        chk("R2", "load count", ob_nld, ex_nld);
        for (int i = 0; i < ex_nld && i < 64; i++) begin
            chk("R2", "load addr", ob_addr[i], ex_addr[i]);
            chk("R2", "load byte count", ob_cnt[i], ex_cnt[i]);
            chk("R3", "load skip", ob_skip[i], ex_skip[i]);
            chk("R3", "load key", ob_key[i], ex_key[i]);
        end
        chk("R8", "new orders", ob_nnew, ex_nnew);
        for (int i = 0; i < ex_nnew && i < 64; i++)
            chk("R2", "order code", ob_code[i], ex_code[i]);
        chk("R7", "order ends", ob_end, ex_end);
        chk("R6", "interrupts", ob_irq, ex_irq);
        chk("R5", "errors", ob_err, ex_err);
        chk("R3", "device releases", ob_fall, ex_fall);
        chk("R1", "fetch count", ob_nfa, ex_nfa);
        for (int i = 0; i < ex_nfa && i < 128; i++)
            chk("R4", "fetch address", ob_fa[i], ex_fa[i]);
    endtask

    task automatic build_random(input int n);
        int wp, ntic;
        bit last, dc, cc;
        logic [7:0] code;
        clr_mem();
        wp = 0;
        for (int k = 0; k < n; k++) begin
            ntic = ($urandom % 5 == 0) ? 1 + $urandom % 2 : 0;
            for (int t = 0; t < ntic; t++) begin
                mem[wp]   = mk0(TIC, 24'((wp + 4) * 4));
                mem[wp+1] = $urandom;
                wp += 4;
            end
            last = (k == n - 1);
            dc = !last && ($urandom % 2 == 1);
            cc = !last && (!dc || ($urandom % 2 == 1));
            code = 8'(1 + $urandom % 4);
            mem[wp]   = mk0(code, 24'($urandom));
            mem[wp+1] = mk1(dc, cc, ($urandom % 2 == 1), ($urandom % 2 == 1),
                            4'h0, 8'($urandom), 16'($urandom));
            wp += 2;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clr_mem();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "busy", busy, 0);
        chk("R10", "mem_req", mem_req, 0);
        chk("R10", "dev_active", dev_active, 0);
        chk("R10", "load_en|irq|end|err", {load_en, irq_req, order_end, prog_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R7: single descriptor with interrupt
        clr_mem();
        put(0, mk0(8'h01, 24'h001000), mk1(0, 0, 1, 0, 4'h0, 8'h3C, 16'h0040));
        run_prog(24'h0, 0);
        chk("R6", "single irq", ob_irq, 1);

        // R3: data chain with changing skip and key
        clr_mem();
        put(0,  mk0(8'h02, 24'h002000), mk1(1, 0, 1, 0, 4'h0, 8'h11, 16'h0010));
        put(8,  mk0(8'h05, 24'h003000), mk1(1, 0, 0, 1, 4'h0, 8'h22, 16'h0020));
        put(16, mk0(8'h07, 24'h004000), mk1(0, 0, 1, 0, 4'h0, 8'h33, 16'h0030));
        run_prog(24'h0, 0);
        chk("R3", "one order for chain", ob_nnew, 1);
        chk("R3", "one end for chain", ob_end, 1);

        // R8: command chain, same order code
        clr_mem();
        put(0, mk0(8'h03, 24'h000100), mk1(0, 1, 0, 0, 4'h0, 8'h01, 16'h0008));
        put(8, mk0(8'h03, 24'h000200), mk1(0, 0, 0, 0, 4'h0, 8'h01, 16'h0008));
        run_prog(24'h0, 0);
        chk("R8", "two orders", ob_nnew, 2);

        // R4: two jumps then a descriptor
        clr_mem();
        put(0,  mk0(TIC, 24'h000040), 32'hFFFF_FFFF);
        put(64, mk0(TIC, 24'h000080), 32'h0);
        put(128, mk0(8'h04, 24'h005000), mk1(0, 0, 0, 0, 4'h0, 8'h44, 16'h0100));
        run_prog(24'h0, 0);
        chk("R4", "load after jumps", ob_nld, 1);

        // R5: three jumps in a row
        clr_mem();
        put(0,  mk0(TIC, 24'h000040), 32'h0);
        put(64, mk0(TIC, 24'h000080), 32'h0);
        put(128, mk0(TIC, 24'h0000C0), 32'h0);
        put(192, mk0(8'h04, 24'h005000), mk1(0, 0, 0, 0, 4'h0, 8'h44, 16'h0100));
        run_prog(24'h0, 0);
        chk("R5", "error pulse", ob_err, 1);
        chk("R5", "no load", ob_nld, 0);

        // R5: runaway jumps in the middle of a data chain
        clr_mem();
        put(0,  mk0(8'h06, 24'h000500), mk1(1, 0, 0, 0, 4'h0, 8'h05, 16'h0004));
        put(8,  mk0(TIC, 24'h000040), 32'h0);
        put(64, mk0(TIC, 24'h000080), 32'h0);
        put(128, mk0(TIC, 24'h000008), 32'h0);
        run_prog(24'h0, 0);
        chk("R5", "mid-chain error no end", ob_end, 0);
        chk("R5", "mid-chain release", ob_fall, 1);

        // R11: both chain flags, data chaining wins
        clr_mem();
        put(0, mk0(8'h01, 24'h000300), mk1(1, 1, 0, 0, 4'h0, 8'h09, 16'h0002));
        put(8, mk0(8'h02, 24'h000400), mk1(0, 0, 0, 0, 4'h0, 8'h0A, 16'h0002));
        run_prog(24'h0, 0);
        chk("R11", "single order", ob_nnew, 1);
        chk("R11", "single end", ob_end, 1);

        // R9: count_zero during fetch ignored
        clr_mem();
        put(0, mk0(8'h01, 24'h000600), mk1(0, 0, 1, 0, 4'h0, 8'h0B, 16'h0003));
        run_prog(24'h0, 1);
        chk("R9", "irq after early count_zero", ob_irq, 1);
        chk("R9", "one end after early count_zero", ob_end, 1);

        // R12: reserved bits set
        clr_mem();
        put(0, mk0(8'h01, 24'h000700), mk1(0, 0, 1, 0, 4'h5, 8'h0C, 16'h0003));
        run_prog(24'h0, 0);
        chk("R12", "reserved error", ob_err, 1);
        chk("R12", "reserved no load", ob_nld, 0);

        // Random programs
        for (int r = 0; r < 24; r++) begin
            build_random(1 + $urandom % 8);
            run_prog(24'h0, ($urandom % 4 == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule